// File: doc/BRIEF.md
# Separable 8x8 Integer Wavelet Tile Transform

This block takes one 8x8 tile of signed integer pixels and produces a single-level two-dimensional forward wavelet decomposition of it. Pixels enter in raster order over a valid/ready handshake. Each completed row of eight pixels is passed through an integer 5/3 lifting stage built only from adders and arithmetic shifts. The stage's four low-pass values are stored in the left half of an internal tile store, and its four high-pass values in the right half. When all eight rows are stored, the same lifting stage is reused on every column of the store. The column results are written back in place, low-pass into the top half and high-pass into the bottom half.

The 64 finished coefficients then leave in raster order over a second valid/ready handshake. Each coefficient carries a two-bit tag naming its subband. A one-cycle pulse marks the transfer of the last coefficient. The block accepts no pixels while a tile is being transformed or drained. After the last coefficient it is ready for the next tile. A typical use is the first stage of a tile-based image coder, fed from a line or tile fetch unit.

Top module: `wav_tile2d`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0 and tile_done is 0.
- R2: Each stored row holds the lifting results of that row's eight pixels: low-pass s[0..3] in columns 0..3 and high-pass d[0..3] in columns 4..7.
- R3: After all eight rows are stored, every column of the store is lifted in place. Low-pass results go to rows 0..3 and high-pass results to rows 4..7. The output value at row r, column c is element r of the lifted column c.
- R4: The lifting stage for a vector x[0..7] computes d[n] = x[2n+1] - floor((x[2n] + x[2n+2]) / 2) and s[n] = x[2n] + floor((d[n-1] + d[n] + 2) / 4) for n = 0..3. Edges are mirrored: x[8] is taken as x[6] and d[-1] as d[0].
- R5: Coefficients leave in raster order (index 8*row + col). out_band is {row >= 4, col >= 4}: 00 approximation, 01 horizontal detail, 10 vertical detail, 11 diagonal detail.
- R6: From the acceptance of the 64th pixel until the last coefficient is accepted, in_ready stays 0. A pixel presented during that time is not consumed and does not change the results.
- R7: While out_valid is 1 and out_ready is 0, out_coef and out_band hold their values.
- R8: tile_done is 1 for exactly the cycle in which the 64th coefficient is transferred, and 0 at every other time.
- R9: Full-scale inputs (DATA_W-bit extremes) produce exact results with no wrap-around. Coefficients are OUT_W = DATA_W + 4 bits wide.
- R10: For a tile of constant value v, the approximation band equals v everywhere and all three detail bands are zero. An all-zero tile yields all zeros.
- R11: In the cycle after tile_done, in_ready is 1 and out_valid is 0, and the next tile is transformed independently of the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Pixel valid |
| in_ready | output | 1 | Block can accept a pixel |
| in_pixel | input | DATA_W | Signed pixel, raster order |
| out_valid | output | 1 | Coefficient valid |
| out_ready | input | 1 | Downstream accepts coefficient |
| out_coef | output | DATA_W+4 | Signed coefficient |
| out_band | output | 2 | Subband tag |
| tile_done | output | 1 | Pulse with last coefficient transfer |

## Verification
The hardest case to reach from the ports is a pixel presented while the block is busy, combined with output stalls that fall on the last coefficient. The stimulus keeps in_valid high with a junk pixel through the row and column passes and checks that in_ready stays low on every one of those cycles. It then checks that the next tile's results are unaffected. Separate tiles drain with a repeating out_ready stall pattern, so that the held coefficient and the done pulse are both observed under backpressure. A checkerboard of full-scale extremes drives the detail values to their largest magnitude to expose any width loss.

// File: rtl/wav_pkg.sv
package wav_pkg;
  localparam int TILE_N = 8;
  localparam int IDX_W  = $clog2(TILE_N);
  localparam int HALF_N = TILE_N / 2;
  localparam int CNT_W  = 2 * IDX_W;

  typedef enum logic [1:0] {
    PH_LOAD = 2'd0,
    PH_ROW  = 2'd1,
    PH_COL  = 2'd2,
    PH_OUT  = 2'd3
  } phase_t;

  typedef enum logic [1:0] {
    BAND_APPROX = 2'b00,
    BAND_HORIZ  = 2'b01,
    BAND_VERT   = 2'b10,
    BAND_DIAG   = 2'b11
  } band_t;
endpackage

// File: rtl/wav_lift8.sv
// Integer 5/3 lifting on eight samples, adders and arithmetic shifts only.
module wav_lift8 #(
  parameter int IN_W  = 14,
  parameter int OUT_W = IN_W + 2
) (
  input  logic [7:0][IN_W-1:0]  x,
  output logic [7:0][OUT_W-1:0] y
);
  import wav_pkg::*;

  localparam logic signed [OUT_W-1:0] RND = OUT_W'(2);

  logic signed [OUT_W-1:0] xe [TILE_N];
  logic signed [OUT_W-1:0] hi [HALF_N];
  logic signed [OUT_W-1:0] lo [HALF_N];

  for (genvar i = 0; i < TILE_N; i++) begin : g_ext
    assign xe[i] = OUT_W'($signed(x[i]));
  end

  // predict step; the right edge mirrors sample 6 into position 8
  for (genvar n = 0; n < HALF_N; n++) begin : g_pred
    localparam int RI = (n == HALF_N - 1) ? TILE_N - 2 : 2 * n + 2;
    assign hi[n] = xe[2*n+1] - ((xe[2*n] + xe[RI]) >>> 1);
  end

  // update step; the left edge reuses the first detail value
  for (genvar n = 0; n < HALF_N; n++) begin : g_upd
    localparam int LI = (n == 0) ? 0 : n - 1;
    assign lo[n] = xe[2*n] + ((hi[LI] + hi[n] + RND) >>> 2);
    assign y[n]          = lo[n];
    assign y[n + HALF_N] = hi[n];
  end
endmodule

// File: rtl/wav_tile_store.sv
// 8x8 coefficient store: row write, column read/write, single-entry read.
module wav_tile_store #(
  parameter int W    = 16,
  parameter int RD_W = 14
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             row_we,
  input  logic [wav_pkg::IDX_W-1:0]        row_idx,
  input  logic [7:0][W-1:0]                row_d,
  input  logic                             col_we,
  input  logic [wav_pkg::IDX_W-1:0]        col_idx,
  input  logic [7:0][W-1:0]                col_d,
  output logic [7:0][RD_W-1:0]             col_q,
  input  logic [wav_pkg::CNT_W-1:0]        rd_idx,
  output logic [W-1:0]                     rd_q
);
  import wav_pkg::*;

  logic [W-1:0] mem [TILE_N*TILE_N];

  always_ff @(posedge clk) begin
    for (int c = 0; c < TILE_N; c++) begin
      if (row_we) mem[{row_idx, IDX_W'(c)}] <= row_d[c];
    end
    for (int r = 0; r < TILE_N; r++) begin
      if (col_we) mem[{IDX_W'(r), col_idx}] <= col_d[r];
    end
  end

  always_comb begin
    for (int r = 0; r < TILE_N; r++) begin
      col_q[r] = mem[{IDX_W'(r), col_idx}][RD_W-1:0];
    end
  end

  assign rd_q = mem[rd_idx];

  // R3
  wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(row_we && col_we));
endmodule

// File: rtl/wav_seq.sv
// Phase sequencer: load rows, lift each row, lift each column, drain.
module wav_seq (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  output logic                      accept,
  output logic [wav_pkg::IDX_W-1:0] pix_idx,
  output logic                      row_we,
  output logic [wav_pkg::IDX_W-1:0] row_idx,
  output logic                      col_we,
  output logic [wav_pkg::IDX_W-1:0] col_idx,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [wav_pkg::CNT_W-1:0] out_idx,
  output logic                      out_fire,
  output logic                      out_last
);
  import wav_pkg::*;

  localparam logic [IDX_W-1:0] LAST_I = IDX_W'(TILE_N - 1);
  localparam logic [CNT_W-1:0] LAST_O = CNT_W'(TILE_N * TILE_N - 1);

  phase_t           ph_q, ph_d;
  logic [IDX_W-1:0] pix_q, pix_d, row_q, row_d, col_q, col_d;
  logic [CNT_W-1:0] out_q, out_d;

  assign in_ready  = (ph_q == PH_LOAD);
  assign accept    = in_ready && in_valid;
  assign row_we    = (ph_q == PH_ROW);
  assign col_we    = (ph_q == PH_COL);
  assign out_valid = (ph_q == PH_OUT);
  assign out_fire  = out_valid && out_ready;
  assign out_last  = (out_q == LAST_O);
  assign pix_idx   = pix_q;
  assign row_idx   = row_q;
  assign col_idx   = col_q;
  assign out_idx   = out_q;

  always_comb begin
    ph_d  = ph_q;
    pix_d = pix_q;
    row_d = row_q;
    col_d = col_q;
    out_d = out_q;
    unique case (ph_q)
      PH_LOAD: if (accept) begin
        pix_d = pix_q + 1'b1;
        if (pix_q == LAST_I) ph_d = PH_ROW;
      end
      PH_ROW: begin
        row_d = row_q + 1'b1;
        ph_d  = (row_q == LAST_I) ? PH_COL : PH_LOAD;
      end
      PH_COL: begin
        col_d = col_q + 1'b1;
        if (col_q == LAST_I) ph_d = PH_OUT;
      end
      PH_OUT: if (out_fire) begin
        out_d = out_q + 1'b1;
        if (out_last) ph_d = PH_LOAD;
      end
      default: ph_d = PH_LOAD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_LOAD;
      pix_q <= '0;
      row_q <= '0;
      col_q <= '0;
      out_q <= '0;
    end else begin
      ph_q  <= ph_d;
      pix_q <= pix_d;
      row_q <= row_d;
      col_q <= col_d;
      out_q <= out_d;
    end
  end

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_idx)));

  // R6
  drain_after_cols_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(col_we));

  // R6
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (row_we || col_we || out_valid) |-> !in_ready);
endmodule

// File: rtl/wav_tile2d.sv
// Single-level separable 2D 5/3 forward transform of an 8x8 tile.
module wav_tile2d #(
  parameter int DATA_W = 12,
  parameter int OUT_W  = DATA_W + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_pixel,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [OUT_W-1:0]  out_coef,
  output logic [1:0]        out_band,
  output logic              tile_done
);
  import wav_pkg::*;

  localparam int MID_W = OUT_W - 2;
  localparam int EXT_W = MID_W - DATA_W;

  logic             accept, row_we, col_we, out_fire, out_last;
  logic [IDX_W-1:0] pix_idx, row_idx, col_idx;
  logic [CNT_W-1:0] out_idx;

  logic [7:0][DATA_W-1:0] row_buf;
  logic [7:0][MID_W-1:0]  col_rd, lift_in;
  logic [7:0][OUT_W-1:0]  lift_out;
  band_t                  band;

  wav_seq u_seq (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .accept(accept),
    .pix_idx(pix_idx), .row_we(row_we), .row_idx(row_idx),
    .col_we(col_we), .col_idx(col_idx),
    .out_valid(out_valid), .out_ready(out_ready), .out_idx(out_idx),
    .out_fire(out_fire), .out_last(out_last)
  );

  // pixel row collector, clock-enabled by the input handshake
  always_ff @(posedge clk) begin
    if (accept) row_buf[pix_idx] <= in_pixel;
  end

  // one lifting stage shared by both passes
  always_comb begin
    for (int i = 0; i < TILE_N; i++) begin
      lift_in[i] = row_we ? {{EXT_W{row_buf[i][DATA_W-1]}}, row_buf[i]} : col_rd[i];
    end
  end

  wav_lift8 #(.IN_W(MID_W), .OUT_W(OUT_W)) u_lift (
    .x(lift_in), .y(lift_out)
  );

  wav_tile_store #(.W(OUT_W), .RD_W(MID_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .row_we(row_we), .row_idx(row_idx), .row_d(lift_out),
    .col_we(col_we), .col_idx(col_idx), .col_d(lift_out),
    .col_q(col_rd),
    .rd_idx(out_idx), .rd_q(out_coef)
  );

  assign band      = band_t'({out_idx[CNT_W-1], out_idx[IDX_W-1]});
  assign out_band  = band;
  assign tile_done = out_fire && out_last;

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tile_done |=> !tile_done);

  // R11
  done_then_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tile_done |=> (in_ready && !out_valid));

  // R8
  done_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tile_done |-> (out_valid && out_ready));
endmodule

// File: tb/wav_tile2d_bench.sv
module wav_tile2d_bench;
  localparam int DATA_W = 12;
  localparam int OUT_W  = DATA_W + 4;
  localparam int PMAX   = (1 << (DATA_W - 1)) - 1;
  localparam int PMIN   = -(1 << (DATA_W - 1));

  logic              clk = 1'b0;
  logic              rst_n;
  logic              in_valid, in_ready, out_valid, out_ready, tile_done;
  logic [DATA_W-1:0] in_pixel;
  logic [OUT_W-1:0]  out_coef;
  logic [1:0]        out_band;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  int tile [64];
  int expv [64];

  always #2 clk = ~clk;

  wav_tile2d #(.DATA_W(DATA_W)) u_wav_tile2d (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pixel(in_pixel), .out_valid(out_valid), .out_ready(out_ready),
    .out_coef(out_coef), .out_band(out_band), .tile_done(tile_done)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // R4 reference lifting on eight integers
  task automatic lift_m(input int a [8], output int r [8]);
    int d [4];
    for (int n = 0; n < 4; n++) begin
      int rt;
      rt = (n == 3) ? a[6] : a[2*n+2];
      d[n] = a[2*n+1] - ((a[2*n] + rt) >>> 1);
    end
    for (int n = 0; n < 4; n++) begin
      int lf;
      lf = (n == 0) ? d[0] : d[n-1];
      r[n]     = a[2*n] + ((lf + d[n] + 2) >>> 2);
      r[n + 4] = d[n];
    end
  endtask

  // R2, R3 separable reference: rows then columns
  task automatic model();
    int mid [64];
    int v [8];
    int o [8];
    for (int r = 0; r < 8; r++) begin
      for (int c = 0; c < 8; c++) v[c] = tile[r*8+c];
      lift_m(v, o);
      for (int c = 0; c < 8; c++) mid[r*8+c] = o[c];
    end
    for (int c = 0; c < 8; c++) begin
      for (int r = 0; r < 8; r++) v[r] = mid[r*8+c];
      lift_m(v, o);
      for (int r = 0; r < 8; r++) expv[r*8+c] = o[r];
    end
  endtask

  task automatic run_tile(input string req, input bit gaps, input bit stall);
    int k;
    int cyc;
    model();
    for (int i = 0; i < 64; i++) begin
      bit taken;
      if (gaps && (i % 5 == 2)) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_pixel = DATA_W'(tile[i]);
      taken = 1'b0;
      while (!taken) begin
        taken = in_ready;
        @(negedge clk);
      end
    end
    // R6: a junk pixel stays offered while the tile is busy
    in_pixel = DATA_W'(PMAX);
    while (!out_valid) begin
      check("R6", "in_ready while busy", int'(in_ready), 0);
      @(negedge clk);
    end
    in_valid = 1'b0;
    k = 0;
    cyc = 0;
    while (k < 64) begin
      out_ready = stall ? ((cyc % 3) != 1) : 1'b1;
      #1;
      if (out_valid) begin
        check("R6", "in_ready while draining", int'(in_ready), 0);
        check(req, $sformatf("coef %0d", k), int'($signed(out_coef)), expv[k]);
        if (out_ready) begin
          check("R5", $sformatf("band %0d", k), int'(out_band),
                ((k / 8 >= 4) ? 2 : 0) + ((k % 8 >= 4) ? 1 : 0));
          check("R8", $sformatf("done at %0d", k), int'(tile_done), (k == 63) ? 1 : 0);
          k++;
        end else begin
          check("R7", "no done while stalled", int'(tile_done), 0);
        end
      end else begin
        check("R5", "out_valid during drain", 0, 1);
        k++;
      end
      cyc++;
      @(negedge clk);
    end
    out_ready = 1'b0;
    check("R11", "in_ready after done", int'(in_ready), 1);
    check("R11", "out_valid after done", int'(out_valid), 0);
    check("R8", "done cleared", int'(tile_done), 0);
  endtask

  task automatic t_reset();
    check("R1", "in_ready", int'(in_ready), 1);
    check("R1", "out_valid", int'(out_valid), 0);
    check("R1", "tile_done", int'(tile_done), 0);
  endtask

  task automatic t_zero();
    for (int i = 0; i < 64; i++) tile[i] = 0;
    run_tile("R10", 1'b0, 1'b0);
  endtask

  task automatic t_const(input int v);
    for (int i = 0; i < 64; i++) tile[i] = v;
    for (int i = 0; i < 64; i++) begin
      int e;
      e = ((i / 8 < 4) && (i % 8 < 4)) ? v : 0;
      model();
      check("R10", "model constant band", expv[i], e);
    end
    run_tile("R10", 1'b1, 1'b0);
  endtask

  task automatic t_ramp();
    for (int i = 0; i < 64; i++) tile[i] = (i % 8) * 37 - (i / 8) * 53 + ((i * i) % 11);
    run_tile("R2", 1'b0, 1'b1);
  endtask

  task automatic t_random(input bit stall);
    for (int i = 0; i < 64; i++) tile[i] = int'($urandom_range(4095)) + PMIN;
    run_tile("R3", stall, stall);
  endtask

  task automatic t_extreme();
    for (int i = 0; i < 64; i++) tile[i] = (((i / 8) + (i % 8)) % 2 == 1) ? PMAX : PMIN;
    run_tile("R9", 1'b0, 1'b1);
    for (int i = 0; i < 64; i++) tile[i] = ((i % 3) == 0) ? PMIN : PMAX;
    run_tile("R9", 1'b1, 1'b0);
  endtask

  task automatic t_edges();
    // R4: single impulse at each edge exercises both mirror rules
    for (int i = 0; i < 64; i++) tile[i] = 0;
    tile[7] = 500; tile[56] = -300; tile[0] = 123; tile[63] = -77;
    run_tile("R4", 1'b0, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_pixel = '0;
    out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_zero();
    t_const(417);
    t_const(-1024);
    t_ramp();
    t_edges();
    t_random(1'b0);
    t_random(1'b1);
    t_extreme();
    t_random(1'b1);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule